// File: doc/BRIEF.md
# Nonvolatile command sequence controller

This block sits between a processor bus and the program/erase engine of a nonvolatile memory array. A command reaches the engine only through a fixed three-step sequence: an aligned 16-bit write into the array space, which captures the target address and data; a write of an operation code to the command register; and a status write with the launch bit set. Any step that breaks this order raises an access error, discards the sequence, and returns the controller to idle.

Launched commands pass to an external execution engine. A `exec_start` pulse carries the command, address and data, and the engine answers with `exec_done`. One launched command can wait behind the one that is executing. An external protection checker watches `chk_addr` and reports through `prot_hit` and `prot_any`. A protected command is dropped and latches a protection-violation flag. Two interrupt enables turn the buffers-empty flag and the command-idle flag into an interrupt request.

Top module: `nvm_cmd_seq`

## Requirements
- R1: After reset, `bufs_empty` and `cmd_idle` are 1, and `acc_err`, `prot_viol`, `blank_flag`, `div_loaded`, `irq`, `exec_start` and `exec_abort` are 0.
- R2: The following sequence, with the engine idle, launches a command:
  - an array write (target 0, `wr_word`=1, even address);
  - a command write (target 3, code in data bits 7:0);
  - a status write (target 4) with data bit 7 set.
  On the clock edge that takes the launch write, `exec_start` pulses for one cycle and carries the buffered code, address and data.
- R3: Only these operation codes are accepted: 0x20 word program, 0x40 sector erase, 0x41 mass erase, 0x05 erase verify and 0x60 sector modify. Any other code raises an access error.
- R4: Each of the following writes sets `acc_err`, returns the sequence to idle, and is discarded:
  - an array write before the divider register (target 1) has been written;
  - an array write that is byte-wide or at an odd address;
  - an array write while `bufs_empty` is 0;
  - a command write with no word buffered;
  - any write other than a command write after the word;
  - any write other than a status write with bit 7 set after the command write (this includes a status write with bit 7 clear, which aborts the sequence).
- R5: A status write accepted in idle or as a launch clears `acc_err` when data bit 4 is 1. A new error in the same cycle takes priority over the clear.
- R6: Protection handling:
  - A command write of 0x41 while `prot_any` is 1, or of 0x20, 0x40 or 0x60 while `prot_hit` is 1, sets `prot_viol` and drops the sequence.
  - While `prot_viol` is 1, any command write other than 0x05 raises an access error.
  - Status data bit 5 clears `prot_viol`.
- R7: A command launched while another is executing is held, and `bufs_empty` reads 0 while it is held. It starts in the cycle in which `exec_done` ends the running command, and `bufs_empty` then returns to 1.
- R8: `cmd_idle` is 1 exactly when no command is held or executing.
- R9: Stop handling:
  - A `stop_req` while a command is held or executing drops both and pulses `exec_abort`.
  - It also sets `acc_err` and returns the sequence to idle.
- R10: When an executing 0x05 command finishes with `exec_blank` at 1, `blank_flag` is set. Status data bit 2 clears it.
- R11: A control write (target 2) in idle loads the interrupt enables: bit 7 for buffers-empty and bit 6 for command-idle. `irq` is the OR of each enabled flag.
- R12: The first divider write in idle sets `div_loaded`, and it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_tgt | input | 3 | Write target: 0 array, 1 divider, 2 control, 3 command, 4 status |
| wr_addr | input | ADDR_W | Array byte address |
| wr_data | input | DATA_W | Write data |
| wr_word | input | 1 | 1 for a 16-bit write, 0 for a byte write |
| stop_req | input | 1 | Stop-mode entry request |
| prot_hit | input | 1 | Checker: `chk_addr` lies in a protected area |
| prot_any | input | 1 | Checker: some protection is active |
| exec_done | input | 1 | Engine finished the running command |
| exec_blank | input | 1 | Engine erase-verify result, valid with `exec_done` |
| chk_addr | output | ADDR_W | Buffered address presented to the protection checker |
| exec_start | output | 1 | One-cycle start pulse to the engine |
| exec_abort | output | 1 | One-cycle abort pulse to the engine |
| exec_cmd | output | 8 | Operation code of the started command |
| exec_addr | output | ADDR_W | Address of the started command |
| exec_data | output | DATA_W | Data of the started command |
| bufs_empty | output | 1 | Buffers free for a new sequence |
| cmd_idle | output | 1 | Nothing held or executing |
| acc_err | output | 1 | Access-error flag |
| prot_viol | output | 1 | Protection-violation flag |
| blank_flag | output | 1 | Erase-verify found the block blank |
| div_loaded | output | 1 | Divider register written since reset |
| irq | output | 1 | Interrupt request |

## Verification
Any corrupted sequence state shows up on the next bus write. That write then raises `acc_err` where it should not, or it fails to raise it. The buffered command reaches the ports one edge after the launch write, through `exec_cmd`, `exec_addr` and `exec_data`. A lost or duplicated held command shows at once as a wrong `bufs_empty` or `cmd_idle`, or as a missing or extra `exec_start` after `exec_done`. The bench compares every flag and every start and abort pulse against its model on every cycle, so a fault is reported within one cycle of reaching a port.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
  localparam int CODE_W = 8;

  typedef enum logic [2:0] {
    TGT_ARRAY  = 3'd0,
    TGT_CLKDIV = 3'd1,
    TGT_CTRL   = 3'd2,
    TGT_CMD    = 3'd3,
    TGT_STAT   = 3'd4
  } tgt_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WORD = 2'd1,
    SQ_CMD  = 2'd2
  } seq_st_e;

  localparam logic [CODE_W-1:0] OP_PROG   = 8'h20;
  localparam logic [CODE_W-1:0] OP_SECT   = 8'h40;
  localparam logic [CODE_W-1:0] OP_MASS   = 8'h41;
  localparam logic [CODE_W-1:0] OP_VERIFY = 8'h05;
  localparam logic [CODE_W-1:0] OP_MODIFY = 8'h60;

  localparam int ST_LAUNCH = 7;
  localparam int ST_PVCLR  = 5;
  localparam int ST_AECLR  = 4;
  localparam int ST_BLCLR  = 2;
  localparam int CT_BEIE   = 7;
  localparam int CT_CIIE   = 6;

  function automatic logic op_legal(input logic [CODE_W-1:0] c);
    return (c == OP_PROG) || (c == OP_SECT) || (c == OP_MASS) ||
           (c == OP_VERIFY) || (c == OP_MODIFY);
  endfunction
endpackage

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_tgt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_word,
  input  logic              stop_abort,
  input  logic              div_loaded,
  input  logic              bufs_empty,
  input  logic              pviol,
  input  logic              prot_hit,
  input  logic              prot_any,
  output logic              launch,
  output logic              seq_err,
  output logic              pv_set,
  output logic              stat_ok,
  output logic              reg_ok,
  output logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_data,
  output logic [CODE_W-1:0] b_cmd
);
  seq_st_e           st, nxt;
  tgt_e              tgt;
  logic [CODE_W-1:0] code;
  logic              cap_w, cap_c, blocked;

  always_comb begin
    tgt     = tgt_e'(wr_tgt);
    code    = wr_data[CODE_W-1:0];
    blocked = (code == OP_MASS) ? prot_any : ((code != OP_VERIFY) && prot_hit);
    launch  = 1'b0;
    seq_err = 1'b0;
    pv_set  = 1'b0;
    stat_ok = 1'b0;
    reg_ok  = 1'b0;
    cap_w   = 1'b0;
    cap_c   = 1'b0;
    nxt     = st;
    if (wr_en) begin
      case (st)
        SQ_IDLE: begin
          case (tgt)
            TGT_ARRAY: begin
              if (!div_loaded || !wr_word || wr_addr[0] || !bufs_empty) seq_err = 1'b1;
              else begin
                cap_w = 1'b1;
                nxt   = SQ_WORD;
              end
            end
            TGT_CLKDIV, TGT_CTRL: reg_ok  = 1'b1;
            TGT_CMD:              seq_err = 1'b1;
            TGT_STAT:             stat_ok = 1'b1;
            default: ;
          endcase
        end
        SQ_WORD: begin
          if (tgt != TGT_CMD) seq_err = 1'b1;
          else if (!op_legal(code) || (pviol && (code != OP_VERIFY))) seq_err = 1'b1;
          else if (blocked) begin
            pv_set = 1'b1;
            nxt    = SQ_IDLE;
          end else begin
            cap_c = 1'b1;
            nxt   = SQ_CMD;
          end
        end
        SQ_CMD: begin
          if ((tgt == TGT_STAT) && wr_data[ST_LAUNCH]) begin
            launch  = 1'b1;
            stat_ok = 1'b1;
            nxt     = SQ_IDLE;
          end else seq_err = 1'b1;
        end
        default: nxt = SQ_IDLE;
      endcase
    end
    if (seq_err) nxt = SQ_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SQ_IDLE;
      b_addr <= '0;
      b_data <= '0;
      b_cmd  <= '0;
    end else begin
      st <= stop_abort ? SQ_IDLE : nxt;
      if (cap_w) begin
        b_addr <= wr_addr;
        b_data <= wr_data;
      end
      if (cap_c) b_cmd <= code;
    end
  end
endmodule

// File: rtl/nvm_exec_track.sv
module nvm_exec_track
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_data,
  input  logic [CODE_W-1:0] l_cmd,
  input  logic              exec_done,
  input  logic              stop_req,
  output logic              stop_abort,
  output logic              verify_done,
  output logic              q_valid,
  output logic              busy,
  output logic              exec_start,
  output logic              exec_abort,
  output logic [CODE_W-1:0] exec_cmd,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [DATA_W-1:0] exec_data
);
  logic [CODE_W-1:0] q_cmd;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_data;
  logic              free;

  assign stop_abort  = stop_req && (busy || q_valid);
  assign free        = !busy || exec_done;
  assign verify_done = !stop_abort && busy && exec_done && (exec_cmd == OP_VERIFY);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid    <= 1'b0;
      busy       <= 1'b0;
      exec_start <= 1'b0;
      exec_abort <= 1'b0;
      q_cmd      <= '0;
      q_addr     <= '0;
      q_data     <= '0;
      exec_cmd   <= '0;
      exec_addr  <= '0;
      exec_data  <= '0;
    end else begin
      exec_start <= 1'b0;
      exec_abort <= 1'b0;
      if (stop_abort) begin
        busy       <= 1'b0;
        q_valid    <= 1'b0;
        exec_abort <= 1'b1;
      end else begin
        if (busy && exec_done) busy <= 1'b0;
        if (q_valid && free) begin
          exec_cmd   <= q_cmd;
          exec_addr  <= q_addr;
          exec_data  <= q_data;
          busy       <= 1'b1;
          exec_start <= 1'b1;
          q_valid    <= 1'b0;
        end else if (launch) begin
          if (free) begin
            exec_cmd   <= l_cmd;
            exec_addr  <= l_addr;
            exec_data  <= l_data;
            busy       <= 1'b1;
            exec_start <= 1'b1;
          end else begin
            q_cmd   <= l_cmd;
            q_addr  <= l_addr;
            q_data  <= l_data;
            q_valid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/nvm_status_flags.sv
module nvm_status_flags
  import nvm_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stat_ok,
  input  logic       reg_ok,
  input  logic [2:0] wr_tgt,
  input  logic [7:0] wr_byte,
  input  logic       seq_err,
  input  logic       pv_set,
  input  logic       stop_abort,
  input  logic       verify_done,
  input  logic       exec_blank,
  input  logic       q_valid,
  input  logic       busy,
  output logic       bufs_empty,
  output logic       cmd_idle,
  output logic       acc_err,
  output logic       prot_viol,
  output logic       blank_flag,
  output logic       div_loaded,
  output logic       irq
);
  logic ie_be, ie_ci;

  assign bufs_empty = !q_valid;
  assign cmd_idle   = !q_valid && !busy;
  assign irq        = (bufs_empty && ie_be) || (cmd_idle && ie_ci);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_err    <= 1'b0;
      prot_viol  <= 1'b0;
      blank_flag <= 1'b0;
      div_loaded <= 1'b0;
      ie_be      <= 1'b0;
      ie_ci      <= 1'b0;
    end else begin
      if (seq_err || stop_abort) acc_err <= 1'b1;
      else if (stat_ok && wr_byte[ST_AECLR]) acc_err <= 1'b0;

      if (pv_set) prot_viol <= 1'b1;
      else if (stat_ok && wr_byte[ST_PVCLR]) prot_viol <= 1'b0;

      if (verify_done && exec_blank) blank_flag <= 1'b1;
      else if (stat_ok && wr_byte[ST_BLCLR]) blank_flag <= 1'b0;

      if (reg_ok && (tgt_e'(wr_tgt) == TGT_CLKDIV)) div_loaded <= 1'b1;
      if (reg_ok && (tgt_e'(wr_tgt) == TGT_CTRL)) begin
        ie_be <= wr_byte[CT_BEIE];
        ie_ci <= wr_byte[CT_CIIE];
      end
    end
  end
endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_tgt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_word,
  input  logic              stop_req,
  input  logic              prot_hit,
  input  logic              prot_any,
  input  logic              exec_done,
  input  logic              exec_blank,
  output logic [ADDR_W-1:0] chk_addr,
  output logic              exec_start,
  output logic              exec_abort,
  output logic [7:0]        exec_cmd,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [DATA_W-1:0] exec_data,
  output logic              bufs_empty,
  output logic              cmd_idle,
  output logic              acc_err,
  output logic              prot_viol,
  output logic              blank_flag,
  output logic              div_loaded,
  output logic              irq
);
  logic              launch, seq_err, pv_set, stat_ok, reg_ok;
  logic              stop_abort, verify_done, q_valid, busy;
  logic [DATA_W-1:0] b_data;
  logic [CODE_W-1:0] b_cmd;

  nvm_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_word(wr_word), .stop_abort(stop_abort),
    .div_loaded(div_loaded), .bufs_empty(bufs_empty), .pviol(prot_viol),
    .prot_hit(prot_hit), .prot_any(prot_any), .launch(launch), .seq_err(seq_err),
    .pv_set(pv_set), .stat_ok(stat_ok), .reg_ok(reg_ok), .b_addr(chk_addr),
    .b_data(b_data), .b_cmd(b_cmd)
  );

  nvm_exec_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_exec (
    .clk(clk), .rst(rst), .launch(launch), .l_addr(chk_addr), .l_data(b_data),
    .l_cmd(b_cmd), .exec_done(exec_done), .stop_req(stop_req),
    .stop_abort(stop_abort), .verify_done(verify_done), .q_valid(q_valid),
    .busy(busy), .exec_start(exec_start), .exec_abort(exec_abort),
    .exec_cmd(exec_cmd), .exec_addr(exec_addr), .exec_data(exec_data)
  );

  nvm_status_flags u_flags (
    .clk(clk), .rst(rst), .stat_ok(stat_ok), .reg_ok(reg_ok), .wr_tgt(wr_tgt),
    .wr_byte(wr_data[7:0]), .seq_err(seq_err), .pv_set(pv_set),
    .stop_abort(stop_abort), .verify_done(verify_done), .exec_blank(exec_blank),
    .q_valid(q_valid), .busy(busy), .bufs_empty(bufs_empty), .cmd_idle(cmd_idle),
    .acc_err(acc_err), .prot_viol(prot_viol), .blank_flag(blank_flag),
    .div_loaded(div_loaded), .irq(irq)
  );
endmodule

// File: rtl/nvm_seq_chk.sv
module nvm_seq_chk (
  input logic clk,
  input logic rst,
  input logic bufs_empty,
  input logic cmd_idle,
  input logic acc_err,
  input logic prot_viol,
  input logic blank_flag,
  input logic div_loaded,
  input logic exec_start,
  input logic exec_abort,
  input logic exec_done,
  input logic exec_blank,
  input logic prot_hit,
  input logic prot_any
);
  p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
    exec_start |-> !cmd_idle);
  p_held_busy_r7: assert property (@(posedge clk) disable iff (rst)
    !bufs_empty |-> !cmd_idle);
  p_abort_flags_r9: assert property (@(posedge clk) disable iff (rst)
    exec_abort |-> (acc_err && cmd_idle));
  p_start_div_r12: assert property (@(posedge clk) disable iff (rst)
    exec_start |-> div_loaded);
  p_div_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    div_loaded |=> div_loaded);
  p_blank_src_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(blank_flag) |-> $past(exec_done && exec_blank));
  p_pviol_src_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(prot_viol) |-> $past(prot_hit || prot_any));
endmodule

bind nvm_cmd_seq nvm_seq_chk u_chk (
  .clk(clk), .rst(rst), .bufs_empty(bufs_empty), .cmd_idle(cmd_idle),
  .acc_err(acc_err), .prot_viol(prot_viol), .blank_flag(blank_flag),
  .div_loaded(div_loaded), .exec_start(exec_start), .exec_abort(exec_abort),
  .exec_done(exec_done), .exec_blank(exec_blank), .prot_hit(prot_hit),
  .prot_any(prot_any)
);

// File: tb/sim_nvm_cmd_seq.sv
`timescale 1ns/1ps
module sim_nvm_cmd_seq;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          wr_en = 0, wr_word = 0, stop_req = 0, prot_hit = 0, prot_any = 0;
  logic          exec_done = 0, exec_blank = 0;
  logic [2:0]    wr_tgt = 0;
  logic [AW-1:0] wr_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic [AW-1:0] chk_addr, exec_addr;
  logic [DW-1:0] exec_data;
  logic [7:0]    exec_cmd;
  logic exec_start, exec_abort, bufs_empty, cmd_idle, acc_err, prot_viol;
  logic blank_flag, div_loaded, irq;

  nvm_cmd_seq #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_word(wr_word), .stop_req(stop_req), .prot_hit(prot_hit),
    .prot_any(prot_any), .exec_done(exec_done), .exec_blank(exec_blank),
    .chk_addr(chk_addr), .exec_start(exec_start), .exec_abort(exec_abort),
    .exec_cmd(exec_cmd), .exec_addr(exec_addr), .exec_data(exec_data),
    .bufs_empty(bufs_empty), .cmd_idle(cmd_idle), .acc_err(acc_err),
    .prot_viol(prot_viol), .blank_flag(blank_flag), .div_loaded(div_loaded), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int            mst;
  logic [AW-1:0] mba, mqa, mea;
  logic [DW-1:0] mbd, mqd, med;
  logic [7:0]    mbc, mqc, mec;
  bit mqv, mbusy, mstart, mabort, macc, mpv, mbl, mdl, mieb, miec;

  always @(posedge clk) begin : model
    bit e, l, pvs, sok, rok, sab, free, vdone;
    int nst;
    logic [7:0] c;
    if (rst) begin
      mst = 0; mqv = 0; mbusy = 0; mstart = 0; mabort = 0;
      macc = 0; mpv = 0; mbl = 0; mdl = 0; mieb = 0; miec = 0;
    end else begin
      e = 0; l = 0; pvs = 0; sok = 0; rok = 0;
      nst = mst;
      c = wr_data[7:0];
      sab = stop_req && (mbusy || mqv);
      vdone = !sab && mbusy && exec_done && (mec == 8'h05);
      if (wr_en) begin
        if (mst == 0) begin
          if (wr_tgt == 0) begin
            if (!mdl || !wr_word || wr_addr[0] || mqv) e = 1;
            else begin mba = wr_addr; mbd = wr_data; nst = 1; end
          end else if (wr_tgt == 1 || wr_tgt == 2) rok = 1;
          else if (wr_tgt == 3) e = 1;
          else if (wr_tgt == 4) sok = 1;
        end else if (mst == 1) begin
          if (wr_tgt != 3) e = 1;
          else if (!(c inside {8'h20, 8'h40, 8'h41, 8'h05, 8'h60}) || (mpv && c != 8'h05)) e = 1;
          else if ((c == 8'h41 && prot_any) || (c != 8'h41 && c != 8'h05 && prot_hit)) begin
            pvs = 1; nst = 0;
          end else begin mbc = c; nst = 2; end
        end else begin
          if (wr_tgt == 4 && wr_data[7]) begin l = 1; sok = 1; nst = 0; end
          else e = 1;
        end
      end
      if (e) nst = 0;
      mstart = 0; mabort = 0;
      if (sab) begin
        mbusy = 0; mqv = 0; mabort = 1; nst = 0;
      end else begin
        free = !mbusy || exec_done;
        if (mbusy && exec_done) mbusy = 0;
        if (mqv && free) begin
          mec = mqc; mea = mqa; med = mqd; mbusy = 1; mstart = 1; mqv = 0;
        end else if (l) begin
          if (free) begin mec = mbc; mea = mba; med = mbd; mbusy = 1; mstart = 1; end
          else begin mqc = mbc; mqa = mba; mqd = mbd; mqv = 1; end
        end
      end
      mst = nst;
      if (e || sab) macc = 1; else if (sok && wr_data[4]) macc = 0;
      if (pvs) mpv = 1; else if (sok && wr_data[5]) mpv = 0;
      if (vdone && exec_blank) mbl = 1; else if (sok && wr_data[2]) mbl = 0;
      if (rok && wr_tgt == 1) mdl = 1;
      if (rok && wr_tgt == 2) begin mieb = wr_data[7]; miec = wr_data[6]; end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R7 bufs_empty", bufs_empty, !mqv);
      chk("R8 cmd_idle", cmd_idle, !mqv && !mbusy);
      chk("R4/R5 acc_err", acc_err, macc);
      chk("R6 prot_viol", prot_viol, mpv);
      chk("R10 blank_flag", blank_flag, mbl);
      chk("R12 div_loaded", div_loaded, mdl);
      chk("R11 irq", irq, ((!mqv) && mieb) || ((!mqv && !mbusy) && miec));
      chk("R2 exec_start", exec_start, mstart);
      chk("R9 exec_abort", exec_abort, mabort);
      if (mstart) begin
        chk("R2 exec_cmd", exec_cmd, mec);
        chk("R2 exec_addr", exec_addr, mea);
        chk("R2 exec_data", exec_data, med);
      end
    end
  end

  task automatic wr(input int t, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit w = 1);
    @(negedge clk);
    wr_en = 1; wr_tgt = 3'(t); wr_addr = a; wr_data = d; wr_word = w;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_done(input bit blank = 0);
    @(negedge clk);
    exec_done = 1; exec_blank = blank;
    @(negedge clk);
    exec_done = 0; exec_blank = 0;
  endtask

  task automatic run_seq(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [7:0] c);
    wr(0, a, d);
    wr(3, 0, {8'h00, c});
    wr(4, 0, 16'h0080);
  endtask

  task automatic clear_flags();
    wr(4, 0, 16'h0034);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset bufs_empty", bufs_empty, 1);
    chk("R1 reset cmd_idle", cmd_idle, 1);
    chk("R1 reset acc_err", acc_err, 0);
    chk("R1 reset div_loaded", div_loaded, 0);
    chk("R1 reset irq", irq, 0);

    wr(0, 16'h0100, 16'h1111);
    chk("R4 array before divider", acc_err, 1);
    clear_flags();
    chk("R5 acc_err cleared", acc_err, 0);
    wr(1, 0, 16'h0027);
    chk("R12 div_loaded set", div_loaded, 1);
    wr(2, 0, 16'h0040);
    chk("R11 irq on idle", irq, 1);

    run_seq(16'h0100, 16'hBEEF, 8'h20);
    chk("R2 start", exec_start, 1);
    chk("R2 cmd", exec_cmd, 8'h20);
    chk("R2 addr", exec_addr, 16'h0100);
    chk("R2 data", exec_data, 16'hBEEF);
    chk("R11 irq low while busy", irq, 0);
    run_seq(16'h0200, 16'h1234, 8'h40);
    chk("R7 held bufs_empty", bufs_empty, 0);
    wr(0, 16'h0300, 16'h5555);
    chk("R4 array while full", acc_err, 1);
    clear_flags();
    pulse_done();
    chk("R7 held starts", exec_start, 1);
    chk("R7 held cmd", exec_cmd, 8'h40);
    chk("R7 bufs_empty back", bufs_empty, 1);
    pulse_done();
    chk("R8 idle after done", cmd_idle, 1);

    wr(0, 16'h0101, 16'h0);
    chk("R4 odd address", acc_err, 1);
    clear_flags();
    wr(0, 16'h0102, 16'h0, 0);
    chk("R4 byte write", acc_err, 1);
    clear_flags();
    wr(0, 16'h0104, 16'h0); wr(0, 16'h0106, 16'h0);
    chk("R4 second word", acc_err, 1);
    clear_flags();
    wr(0, 16'h0108, 16'h0); wr(2, 0, 16'h0080);
    chk("R4 register after word", acc_err, 1);
    chk("R11 control write discarded", irq, 1);
    clear_flags();
    wr(3, 0, 16'h0020);
    chk("R4 command without word", acc_err, 1);
    clear_flags();
    wr(0, 16'h010A, 16'h0); wr(3, 0, 16'h0020); wr(3, 0, 16'h0040);
    chk("R4 second command", acc_err, 1);
    clear_flags();
    wr(0, 16'h010C, 16'h0); wr(3, 0, 16'h0033);
    chk("R3 illegal code", acc_err, 1);
    clear_flags();
    wr(0, 16'h010E, 16'h0); wr(3, 0, 16'h0020); wr(1, 0, 16'h0011);
    chk("R4 non-status after command", acc_err, 1);
    clear_flags();
    wr(0, 16'h0110, 16'h0); wr(3, 0, 16'h0020); wr(4, 0, 16'h0000);
    chk("R4 abort by zero", acc_err, 1);
    chk("R4 abort no start", exec_start, 0);
    clear_flags();

    prot_hit = 1;
    wr(0, 16'h0120, 16'h0); wr(3, 0, 16'h0060);
    chk("R6 protected modify", prot_viol, 1);
    wr(4, 0, 16'h0080);
    chk("R6 dropped command no start", exec_start, 0);
    wr(0, 16'h0122, 16'h0); wr(3, 0, 16'h0040);
    chk("R6 blocked while set", acc_err, 1);
    clear_flags();
    chk("R6 cleared", prot_viol, 0);
    prot_hit = 0; prot_any = 1;
    wr(0, 16'h0124, 16'h0); wr(3, 0, 16'h0041);
    chk("R6 mass with protection", prot_viol, 1);
    run_seq(16'h0000, 16'h0, 8'h05);
    chk("R6 verify allowed", exec_cmd, 8'h05);
    pulse_done(1);
    chk("R10 blank set", blank_flag, 1);
    wr(4, 0, 16'h0004);
    chk("R10 blank cleared", blank_flag, 0);
    run_seq(16'h0000, 16'h0, 8'h05);
    pulse_done(0);
    chk("R10 not blank", blank_flag, 0);
    prot_any = 0;
    clear_flags();

    run_seq(16'h0000, 16'h0, 8'h41);
    chk("R3 mass accepted", exec_cmd, 8'h41);
    pulse_done();
    run_seq(16'h0130, 16'hA5A5, 8'h60);
    chk("R3 modify accepted", exec_cmd, 8'h60);
    pulse_done();

    run_seq(16'h0140, 16'h0F0F, 8'h20);
    run_seq(16'h0142, 16'hF0F0, 8'h20);
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk("R9 abort pulse", exec_abort, 1);
    chk("R9 acc_err", acc_err, 1);
    chk("R9 idle", cmd_idle, 1);
    clear_flags();
    run_seq(16'h0150, 16'h7777, 8'h20);
    chk("R9 restart after stop", exec_start, 1);
    pulse_done();
    repeat (3) @(negedge clk);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule